// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Slave

This block models the slave side of a small serial EEPROM whose two bus wires are not sampled on a clock of their own. A host moves them by register writes, and each write hands the block one new pair of levels. Every update arrives as a one-cycle strobe that carries the new clock-wire (SCL) and data-wire (SDA) levels. The block compares each pair with the pair it stored last time. From that comparison it finds bus start and stop conditions, rising clock edges, and edges where the data wire moved at the same moment.

A single step counter drives the whole transaction. After a start, the first eight good clock edges shift a command byte into the block. An acknowledge follows. The next eight edges shift in a word address. During those eight edges, if the command asked for a read, the block drives the byte it fetched last time onto SDA, most significant bit first. The block then loads the addressed byte from its built-in 256-byte table, schedules one more acknowledge, and returns to idle. The table has fixed contents and cannot be written. The level the host reads back on SDA is always the level the block stored last. That level is the host's own level unless the block drove the wire for an acknowledge or a read bit.

Top module: `bitbang_eeprom_slave`

## Requirements
- R1: After synchronous active-low reset, sda_out is 1, the step counter is 0 and no acknowledge is pending. The previous SCL and SDA levels are both taken as 1.
- R2: An update in which SCL was 1 and stays 1 while SDA goes from 1 to 0 is a start. It sets the step counter to 1 and clears the command byte.
- R3: While the step counter is 0 and no acknowledge is pending, every update except a start leaves the sequence state unchanged. sda_out then equals the sda_in level of that update.
- R4: A data bit is taken only on an update where SCL goes from 0 to 1 and SDA equals its previous stored level. A rising edge on which SDA also changed counts no bit.
- R5: On a rising SCL update while an acknowledge is pending, sda_out becomes 0 whatever the host drove, and the pending flag clears. This holds even if SDA changed on that edge.
- R6: The first eight counted bits form the command byte, MSB first, and an acknowledge is scheduled after the eighth. The next eight counted bits form the word address, MSB first. After the last address bit, the addressed byte is loaded, an acknowledge is scheduled, and the step counter returns to 0.
- R7: When the command byte's bit 0 is 1 (read), each counted address-phase bit drives sda_out to the data register's bit 7, and the data register then shifts left by one.
- R8: The table holds 0x80, 0x08, 0x04, 0x0D, 0x0A, 0x01, 0x40, 0x00 at addresses 0 to 7, and 0x00 at every other address.
- R9: An update in which SCL is 1 before and after while SDA goes from 0 to 1 is a stop. It changes no sequence state, and sda_out becomes 1.
- R10: Without a strobe, sda_out and all sequence state hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | One-cycle strobe: a new wire-level pair is present |
| scl_in | input | 1 | New clock-wire level for this update |
| sda_in | input | 1 | New data-wire level driven by the host for this update |
| sda_out | output | 1 | Data-wire level as the host reads it back |

## Verification
The bench inserts a rising clock edge on which SDA also flips inside the command phase. A block that counted that edge would acknowledge one bit early. It then clocks full bytes with no start first. A block that did not guard the idle state would acknowledge a byte that was never framed. An acknowledge edge is given with the host holding SDA high, so a block that let the host level through would return 1 instead of 0. Two back-to-back read transactions read out table bytes. A block with a wrong shift order or a wrong load point would return reversed or stale bytes. Long random wire sequences with gaps between strobes are compared against a reference model. Those sequences catch wrong start/stop priority and drift across strobe-free cycles.

// File: rtl/bbe_pkg.sv
// Package bbe_pkg: shared types and the reset-time table contents for the
// bit-banged EEPROM slave. Assumes byte-wide storage.
package bbe_pkg;

    localparam int unsigned BYTE_W = 8;

    // Classification of one wire update against the stored levels.
    typedef enum logic [2:0] {
        EV_NONE      = 3'd0,
        EV_START     = 3'd1,
        EV_STOP      = 3'd2,
        EV_RISE_OK   = 3'd3,
        EV_RISE_SKEW = 3'd4
    } bus_ev_t;

    // Fixed table contents: a short header, zero everywhere else.
    function automatic logic [BYTE_W-1:0] boot_byte(input int unsigned a);
        case (a)
            0:       boot_byte = 8'h80;
            1:       boot_byte = 8'h08;
            2:       boot_byte = 8'h04;
            3:       boot_byte = 8'h0D;
            4:       boot_byte = 8'h0A;
            5:       boot_byte = 8'h01;
            6:       boot_byte = 8'h40;
            default: boot_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/bbe_rom.sv
// Module bbe_rom: combinational lookup into the fixed byte table.
// Assumes the table never changes after build; no write path.
module bbe_rom #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic [bbe_pkg::BYTE_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [bbe_pkg::BYTE_W-1:0] table_q [DEPTH];

    // Build one table entry per address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = bbe_pkg::boot_byte(i);
    end

    // Select the addressed entry.
    always_comb rd_data = table_q[addr];

endmodule

// File: rtl/bbe_busev.sv
// Module bbe_busev: classifies a new SCL/SDA pair against the stored pair.
// Assumes it is evaluated only when a strobe is present; purely combinational.
module bbe_busev (
    input  logic             prev_scl,
    input  logic             prev_sda,
    input  logic             new_scl,
    input  logic             new_sda,
    output bbe_pkg::bus_ev_t ev
);
    // Start/stop take priority over edges; an edge with a moving SDA is marked skewed.
    always_comb begin
        ev = bbe_pkg::EV_NONE;
        if (prev_scl && new_scl && (prev_sda != new_sda)) begin
            ev = new_sda ? bbe_pkg::EV_STOP : bbe_pkg::EV_START;
        end else if (!prev_scl && new_scl) begin
            ev = (prev_sda == new_sda) ? bbe_pkg::EV_RISE_OK : bbe_pkg::EV_RISE_SKEW;
        end
    end

endmodule

// File: rtl/bitbang_eeprom_slave.sv
// Module bitbang_eeprom_slave: slave model of a serial EEPROM fed by sampled
// wire levels. One step counter sequences command bits, acknowledges,
// address bits and read data. Assumes one update per strobe and a host that
// reads sda_out back as the wire level.
module bitbang_eeprom_slave #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_valid,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out
);
    import bbe_pkg::*;

    localparam int unsigned CMD_END  = BYTE_W + 1;        // count after last command bit
    localparam int unsigned ADDR_END = CMD_END + ADDR_W;  // count after last address bit
    localparam int unsigned TICK_W   = $clog2(ADDR_END + 1);

    logic              scl_q, sda_q;
    logic [TICK_W-1:0] tick_q, tick_n;
    logic              ack_q, ack_n;
    logic [BYTE_W-1:0] cmd_q, cmd_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [BYTE_W-1:0] data_q, data_n;
    logic              drv_n;
    logic [BYTE_W-1:0] rom_byte;
    bus_ev_t           ev;

    bbe_busev u_ev (
        .prev_scl (scl_q),
        .prev_sda (sda_q),
        .new_scl  (scl_in),
        .new_sda  (sda_in),
        .ev       (ev)
    );

    bbe_rom #(.ADDR_W(ADDR_W)) u_rom (
        .addr    (addr_n),
        .rd_data (rom_byte)
    );

    // Next-state sequencing for one wire update.
    always_comb begin
        tick_n = tick_q;
        ack_n  = ack_q;
        cmd_n  = cmd_q;
        addr_n = addr_q;
        data_n = data_q;
        drv_n  = sda_in;
        if (ev == EV_START) begin
            tick_n = TICK_W'(1);
            cmd_n  = '0;
        end else if (ev == EV_STOP) begin
            tick_n = tick_q;
        end else if (tick_q == '0 && !ack_q) begin
            tick_n = tick_q;
        end else if (ev == EV_RISE_OK || ev == EV_RISE_SKEW) begin
            if (ack_q) begin
                drv_n = 1'b0;
                ack_n = 1'b0;
            end else if (ev == EV_RISE_OK) begin
                if (tick_q < TICK_W'(CMD_END)) begin
                    cmd_n  = {cmd_q[BYTE_W-2:0], sda_in};
                    tick_n = tick_q + 1'b1;
                    if (tick_q == TICK_W'(CMD_END - 1)) ack_n = 1'b1;
                end else begin
                    if (cmd_q[0]) drv_n = data_q[BYTE_W-1];
                    addr_n = {addr_q[ADDR_W-2:0], sda_in};
                    data_n = {data_q[BYTE_W-2:0], 1'b0};
                    tick_n = tick_q + 1'b1;
                    if (tick_q == TICK_W'(ADDR_END - 1)) begin
                        data_n = rom_byte;
                        ack_n  = 1'b1;
                        tick_n = '0;
                    end
                end
            end
        end
    end

    // Register the update when a strobe arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            tick_q <= '0;
            ack_q  <= 1'b0;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (upd_valid) begin
            scl_q  <= scl_in;
            sda_q  <= drv_n;
            tick_q <= tick_n;
            ack_q  <= ack_n;
            cmd_q  <= cmd_n;
            addr_q <= addr_n;
            data_q <= data_n;
        end
    end

    // The host sees the last stored data-wire level.
    assign sda_out = sda_q;

    // R2: a start restarts the command phase.
    a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && scl_q && scl_in && sda_q && !sda_in) |=> (tick_q == TICK_W'(1) && cmd_q == '0));

    // R3: idle state ignores everything but a start.
    a_r3_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && tick_q == '0 && !ack_q && !(scl_q && scl_in && sda_q && !sda_in))
        |=> (tick_q == '0 && !ack_q && sda_out == $past(sda_in)));

    // R5: a rising edge with a pending acknowledge pulls the wire low.
    a_r5_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && ack_q && !scl_q && scl_in) |=> (!sda_out && !ack_q));

    // R6: the step counter never passes the last address step.
    a_r6_tick_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q < TICK_W'(ADDR_END));

    // R10: nothing moves without a strobe.
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(sda_out) && $stable(tick_q) && $stable(ack_q)));

endmodule

// File: tb/bitbang_eeprom_slave_test.sv
module bitbang_eeprom_slave_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_valid = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic sda_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_tick, m_cmd, m_addr, m_data;
    bit m_ack, m_scl, m_sda;
    string m_tag;

    always #10 clk = ~clk;  // 50 MHz

    bitbang_eeprom_slave uut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid),
        .scl_in(scl_in), .sda_in(sda_in), .sda_out(sda_out)
    );

    function automatic int exp_byte(input int a);
        int t[8] = '{8'h80, 8'h08, 8'h04, 8'h0D, 8'h0A, 8'h01, 8'h40, 8'h00};
        return (a < 8) ? t[a] : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tick = 0; m_cmd = 0; m_addr = 0; m_data = 0;
        m_ack = 0; m_scl = 1; m_sda = 1; m_tag = "R1";
    endtask

    // Reference step written from the requirements.
    task automatic model_step(input bit s, input bit d);
        bit drv = d;
        m_tag = "R3";
        if (m_scl && s && m_sda != d) begin
            if (!d) begin m_tick = 1; m_cmd = 0; m_tag = "R2"; end
            else m_tag = "R9";
        end else if (m_tick == 0 && !m_ack) begin
            m_tag = "R3";
        end else if (!m_scl && s) begin
            if (m_ack) begin drv = 0; m_ack = 0; m_tag = "R5"; end
            else if (m_sda == d) begin
                m_tag = "R6";
                if (m_tick < 9) begin
                    m_cmd = ((m_cmd << 1) | d) & 8'hFF;
                    m_tick++;
                    if (m_tick == 9) m_ack = 1;
                end else begin
                    if (m_cmd & 1) begin drv = (m_data >> 7) & 1; m_tag = "R7"; end
                    m_addr = ((m_addr << 1) | d) & 8'hFF;
                    m_data = (m_data << 1) & 8'hFF;
                    m_tick++;
                    if (m_tick == 17) begin
                        m_data = exp_byte(m_addr); m_ack = 1; m_tick = 0;
                    end
                end
            end else m_tag = "R4";
        end
        m_scl = s;
        m_sda = drv;
    endtask

    // One strobed update, then compare the read-back level against the model.
    task automatic upd(input bit s, input bit d);
        @(negedge clk);
        scl_in = s; sda_in = d; upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
        model_step(s, d);
        check(m_tag, sda_out, m_sda);
    endtask

    task automatic send_byte(input int b);
        for (int i = 7; i >= 0; i--) begin
            upd(1'b0, b[i]);
            upd(1'b1, b[i]);
        end
    endtask

    task automatic ack_clock(input bit host);
        upd(1'b0, host);
        upd(1'b1, host);
    endtask

    task automatic do_start();
        upd(1'b1, 1'b1);
        upd(1'b1, 1'b0);
    endtask

    task automatic do_stop();
        upd(1'b0, 1'b0);
        upd(1'b1, 1'b0);
        upd(1'b1, 1'b1);
    endtask

    // Read byte at 'a': a first transaction loads it, a second shifts it out.
    task automatic read_byte(input int a, output int got);
        got = 0;
        do_start(); send_byte(8'hA1); ack_clock(1); send_byte(a); ack_clock(1); do_stop();
        do_start(); send_byte(8'hA1); ack_clock(1);
        for (int i = 7; i >= 0; i--) begin
            upd(1'b0, 1'b1);
            upd(1'b1, 1'b1);
            got = (got << 1) | sda_out;
        end
        ack_clock(1); do_stop();
    endtask

    initial begin
        int got;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", sda_out, 1);

        // R3: a full byte and an extra edge without a start: no acknowledge.
        send_byte(8'hFF);
        ack_clock(1);
        check("R3", sda_out, 1);

        // R2/R4/R5: skewed edge inside the command byte is not counted.
        do_start();
        send_byte(8'hF0 >> 4);   // 4 bits would be wrong; send explicit pattern below
        do_stop();
        do_start();
        for (int i = 0; i < 4; i++) begin upd(1'b0, 1'b1); upd(1'b1, 1'b1); end
        upd(1'b0, 1'b0); upd(1'b1, 1'b1);        // skewed rise: ignored (R4)
        for (int i = 0; i < 4; i++) begin upd(1'b0, 1'b1); upd(1'b1, 1'b1); end
        check("R4", sda_out, 1);                 // only eight counted, no ack yet
        ack_clock(1);
        check("R5", sda_out, 0);                 // ack despite host high
        do_stop();
        check("R9", sda_out, 1);

        // R7/R8: read table bytes back.
        for (int a = 0; a < 8; a++) begin
            read_byte(a, got);
            check("R8", got, exp_byte(a));
        end
        read_byte(8'hC3, got);
        check("R8", got, 0);

        // R10: no strobe, nothing moves.
        @(negedge clk); scl_in = 0; sda_in = 0;
        repeat (5) @(negedge clk);
        check("R10", sda_out, m_sda);

        // Random wire sequences with strobe gaps, fixed seed.
        begin
            int unsigned seed = 32'h1234_5678;
            void'($urandom(seed));
            for (int i = 0; i < 3000; i++) begin
                bit s = $urandom_range(0, 1);
                bit d = ($urandom_range(0, 3) != 0) ? m_sda : ~m_sda;
                if ($urandom_range(0, 7) == 0) begin
                    @(negedge clk); scl_in = ~s; sda_in = ~d;
                    @(negedge clk);
                    check("R10", sda_out, m_sda);
                end
                upd(s, d);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule